// File: doc/BRIEF.md
# Multi-Granule Memory Tag Checker

This block decides whether one memory access may proceed by comparing the 4-bit tag carried in the pointer with the tag stored for every 16-byte granule that the access touches. Stored tags are packed two per byte: the lower nibble belongs to the even granule and the upper nibble to the odd granule. The checker fetches those bytes through a single synchronous read port, one byte at a time in ascending address order. It stops at the first granule whose stored tag differs from the pointer tag.

A request carries the tagged pointer, the access length in bytes and the element size as a power of two. Two configuration inputs give the rest of the context. The first says whether checking is enabled for each address half, with the half chosen by pointer bit 55. The second says which of the two pages the access can touch has tag storage. When the check finishes, the block gives a one-cycle done pulse with a pass flag. On a failure it also reports the address of the first element that starts inside the failing granule, which is the granule offset rounded up to a whole element.

Top module: `mtc_tag_checker`

## Requirements
- R1: After reset, `done`, `busy` and `tag_rd_en` are all low.
- R2: If `tbi_en[req_addr[55]]` is 0, the request is unchecked: the cycle after acceptance shows `done`=1, `pass`=1 and `fault_addr`=0, and no tag byte is read.
- R3: The granules checked run from `req_addr[55:0]>>4` up to `(req_addr[55:0]+req_total-1)>>4`. If every one of them matches, the result is `pass`=1 with `fault_addr`=0.
- R4: The tag of granule g sits in tag byte g>>1. It is bits 3:0 of that byte when g is even and bits 7:4 when g is odd, so an access with address bit 4 set starts on the upper nibble. The pointer tag is `req_addr[59:56]`.
- R5: Granules are compared in ascending order and checking stops at the first mismatch, which gives `pass`=0.
- R6: On a failure at granule index n, counted from the first granule, `fault_addr` = `req_addr` + off. Here off is 0 for n=0 and otherwise 16n minus `req_addr[3:0]`, rounded up to a multiple of 2^`req_esz_log2`.
- R7: A page is 4 KiB. A granule on the starting page uses `pg_tagged[0]`, and a granule on the following page uses `pg_tagged[1]`. A granule on a page whose flag is 0 counts as matching.
- R8: Each tag byte is read at most once. Within a request, successive `tag_rd_addr` values increase by exactly 1, and reading stops at the byte holding the last granule compared.
- R9: `done` is a one-cycle pulse. `busy` is high from acceptance until done, and no read is issued while not busy. A `req_valid` seen while busy or while done is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a check (accepted when idle and done is low) |
| req_addr | input | 64 | Tagged pointer; tag in 59:56, half select in 55 |
| req_total | input | 9 | Access length in bytes, 1 to 256 |
| req_esz_log2 | input | 4 | log2 of element size, 0 to 8 |
| tbi_en | input | 2 | Checking enabled per address half |
| pg_tagged | input | 2 | Tag storage present: [0] start page, [1] next page |
| tag_rd_en | output | 1 | Tag byte read strobe |
| tag_rd_addr | output | 51 | Tag byte index (address bits 55:5) |
| tag_rd_data | input | 8 | Tag byte, valid the cycle after the read is sampled |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with done |
| fault_addr | output | 64 | First failing element address, valid with done |

## Verification
The assertions take for granted that `req_total` lies between 1 and 256 and is a whole number of elements. They also assume `req_esz_log2` is at most 8 and that pointer plus length does not wrap the 56-bit address. Under those conditions the reported fault address lies between the start and the end of the access. Random stimulus produces the length as an element count shifted by the element size and keeps addresses in a small low window. Tag memory is a registered read array with exactly one cycle of latency, as the read port expects.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int unsigned MTC_TAG_W  = 4;
  localparam int unsigned MTC_BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CMP  = 2'd2
  } mtc_state_e;
endpackage

// File: rtl/mtc_span_calc.sv
module mtc_span_calc #(
  parameter int unsigned VA_W     = 56,
  parameter int unsigned GRAN_LOG = 4,
  parameter int unsigned SZ_W     = 9,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned TA_W     = 51
) (
  input  logic [VA_W-1:0]  va,
  input  logic [SZ_W-1:0]  total,
  output logic [CNT_W-1:0] gcount,
  output logic [TA_W-1:0]  first_byte,
  output logic             first_odd
);
  localparam int unsigned GI_W = VA_W - GRAN_LOG;

  logic [VA_W-1:0] last_va;
  logic [GI_W-1:0] g_first;
  logic [GI_W-1:0] g_last;

  assign last_va    = va + VA_W'(total) - VA_W'(1);
  assign g_first    = va[VA_W-1:GRAN_LOG];
  assign g_last     = last_va[VA_W-1:GRAN_LOG];
  assign gcount     = CNT_W'(g_last - g_first) + CNT_W'(1);
  assign first_byte = va[VA_W-1:GRAN_LOG+1];
  assign first_odd  = va[GRAN_LOG];
endmodule

// File: rtl/mtc_nibble_cmp.sv
module mtc_nibble_cmp #(
  parameter int unsigned TAG_W = 4,
  parameter int unsigned LANES = 2
) (
  input  logic [LANES*TAG_W-1:0] tag_byte,
  input  logic [TAG_W-1:0]       ptag,
  input  logic                   skip,
  input  logic                   odd,
  input  logic                   pair_ok,
  output logic                   mis_first,
  output logic                   mis_second,
  output logic [1:0]             step
);
  logic [LANES-1:0] lane_mis;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mis[i] = !skip && (tag_byte[i*TAG_W +: TAG_W] != ptag);
  end

  assign mis_first  = odd ? lane_mis[LANES-1] : lane_mis[0];
  assign mis_second = !odd && pair_ok && lane_mis[LANES-1];
  assign step       = (!odd && pair_ok) ? 2'd2 : 2'd1;
endmodule

// File: rtl/mtc_fault_addr.sv
module mtc_fault_addr #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned GRAN_LOG = 4,
  parameter int unsigned CNT_W    = 6,
  parameter int unsigned ESZ_W    = 4,
  parameter int unsigned OFF_W    = 10
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [CNT_W-1:0]  fail_idx,
  input  logic [ESZ_W-1:0]  esz_log2,
  output logic [ADDR_W-1:0] fault
);
  logic [OFF_W-1:0] gran_off;
  logic [OFF_W-1:0] raw_off;
  logic [OFF_W-1:0] mask;
  logic [OFF_W-1:0] rounded;

  assign gran_off = OFF_W'(fail_idx) << GRAN_LOG;
  assign raw_off  = (fail_idx == '0) ? '0 : gran_off - OFF_W'(ptr[GRAN_LOG-1:0]);
  assign mask     = (OFF_W'(1) << esz_log2) - OFF_W'(1);
  assign rounded  = (raw_off + mask) & ~mask;
  assign fault    = ptr + ADDR_W'(rounded);
endmodule

// File: rtl/mtc_tag_checker.sv
module mtc_tag_checker
  import mtc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned TAG_LSB  = 56,
  parameter int unsigned SEL_BIT  = 55,
  parameter int unsigned GRAN_LOG = 4,
  parameter int unsigned PAGE_LOG = 12,
  parameter int unsigned MAX_LOG  = 8,
  parameter int unsigned ESZ_W    = 4
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     req_valid,
  input  logic [ADDR_W-1:0]                        req_addr,
  input  logic [MAX_LOG:0]                         req_total,
  input  logic [ESZ_W-1:0]                         req_esz_log2,
  input  logic [1:0]                               tbi_en,
  input  logic [1:0]                               pg_tagged,
  output logic                                     tag_rd_en,
  output logic [TAG_LSB-GRAN_LOG-2:0]              tag_rd_addr,
  input  logic [MTC_BYTE_W-1:0]                    tag_rd_data,
  output logic                                     busy,
  output logic                                     done,
  output logic                                     pass,
  output logic [ADDR_W-1:0]                        fault_addr
);
  localparam int unsigned VA_W    = TAG_LSB;
  localparam int unsigned BYTE_SH = GRAN_LOG + 1;
  localparam int unsigned TA_W    = VA_W - BYTE_SH;
  localparam int unsigned SZ_W    = MAX_LOG + 1;
  localparam int unsigned CNT_W   = MAX_LOG - GRAN_LOG + 2;
  localparam int unsigned OFF_W   = MAX_LOG + 2;
  localparam int unsigned PG_SH   = PAGE_LOG - BYTE_SH;
  localparam int unsigned LANES   = MTC_BYTE_W / MTC_TAG_W;

  mtc_state_e            st_q;
  logic                  done_q, pass_q, rd_en_q, odd_q;
  logic [ADDR_W-1:0]     fault_q, addr_q;
  logic [TA_W-1:0]       rd_addr_q;
  logic [SZ_W-1:0]       total_q;
  logic [ESZ_W-1:0]      esz_q;
  logic [MTC_TAG_W-1:0]  ptag_q;
  logic [CNT_W-1:0]      cnt_q, g_q;
  logic [1:0]            tagged_q;

  logic [CNT_W-1:0]      span_cnt;
  logic [TA_W-1:0]       span_byte;
  logic                  span_odd;
  logic                  accept, bypass;
  logic                  same_page, skip, pair_ok;
  logic                  mis_first, mis_second;
  logic [1:0]            step;
  logic [CNT_W-1:0]      g_next, fail_idx;
  logic [ADDR_W-1:0]     fault_w;

  assign accept = req_valid && (st_q == ST_IDLE) && !done_q;
  assign bypass = !tbi_en[req_addr[SEL_BIT]];

  mtc_span_calc #(
    .VA_W(VA_W), .GRAN_LOG(GRAN_LOG), .SZ_W(SZ_W), .CNT_W(CNT_W), .TA_W(TA_W)
  ) span_i (
    .va(req_addr[VA_W-1:0]), .total(req_total),
    .gcount(span_cnt), .first_byte(span_byte), .first_odd(span_odd)
  );

  assign same_page = (rd_addr_q[TA_W-1:PG_SH] == addr_q[VA_W-1:PAGE_LOG]);
  assign skip      = same_page ? !tagged_q[0] : !tagged_q[1];
  assign pair_ok   = (g_q + CNT_W'(1)) < cnt_q;

  mtc_nibble_cmp #(.TAG_W(MTC_TAG_W), .LANES(LANES)) cmp_i (
    .tag_byte(tag_rd_data), .ptag(ptag_q), .skip(skip), .odd(odd_q),
    .pair_ok(pair_ok), .mis_first(mis_first), .mis_second(mis_second),
    .step(step)
  );

  assign g_next   = g_q + CNT_W'(step);
  assign fail_idx = mis_first ? g_q : g_q + CNT_W'(1);

  mtc_fault_addr #(
    .ADDR_W(ADDR_W), .GRAN_LOG(GRAN_LOG), .CNT_W(CNT_W), .ESZ_W(ESZ_W), .OFF_W(OFF_W)
  ) fault_i (
    .ptr(addr_q), .fail_idx(fail_idx), .esz_log2(esz_q), .fault(fault_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      rd_en_q   <= 1'b0;
      odd_q     <= 1'b0;
      fault_q   <= '0;
      addr_q    <= '0;
      rd_addr_q <= '0;
      total_q   <= '0;
      esz_q     <= '0;
      ptag_q    <= '0;
      cnt_q     <= '0;
      g_q       <= '0;
      tagged_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            if (bypass) begin
              done_q  <= 1'b1;
              pass_q  <= 1'b1;
              fault_q <= '0;
            end else begin
              addr_q    <= req_addr;
              total_q   <= req_total;
              esz_q     <= req_esz_log2;
              ptag_q    <= req_addr[TAG_LSB +: MTC_TAG_W];
              tagged_q  <= pg_tagged;
              cnt_q     <= span_cnt;
              g_q       <= '0;
              odd_q     <= span_odd;
              rd_addr_q <= span_byte;
              rd_en_q   <= 1'b1;
              st_q      <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          rd_en_q <= 1'b0;
          st_q    <= ST_CMP;
        end
        ST_CMP: begin
          if (mis_first || mis_second) begin
            done_q  <= 1'b1;
            pass_q  <= 1'b0;
            fault_q <= fault_w;
            st_q    <= ST_IDLE;
          end else if (g_next >= cnt_q) begin
            done_q  <= 1'b1;
            pass_q  <= 1'b1;
            fault_q <= '0;
            st_q    <= ST_IDLE;
          end else begin
            g_q       <= g_next;
            odd_q     <= 1'b0;
            rd_addr_q <= rd_addr_q + TA_W'(1);
            rd_en_q   <= 1'b1;
            st_q      <= ST_WAIT;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign tag_rd_en   = rd_en_q;
  assign tag_rd_addr = rd_addr_q;
  assign busy        = (st_q != ST_IDLE);
  assign done        = done_q;
  assign pass        = pass_q;
  assign fault_addr  = fault_q;

  // Checker state: last read address within the current request.
  logic            chk_seen_q;
  logic [TA_W-1:0] chk_last_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      chk_seen_q <= 1'b0;
      chk_last_q <= '0;
    end else if (accept) begin
      chk_seen_q <= 1'b0;
    end else if (tag_rd_en) begin
      chk_seen_q <= 1'b1;
      chk_last_q <= tag_rd_addr;
    end
  end

  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (rst)
    accept && bypass |=> done && pass && !tag_rd_en); // R2
  AST_RD_ASCEND: assert property (@(posedge clk) disable iff (rst)
    tag_rd_en && chk_seen_q |-> tag_rd_addr == chk_last_q + TA_W'(1)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tag_rd_en); // R9
  AST_FAULT_INSIDE: assert property (@(posedge clk) disable iff (rst)
    done && !pass |-> (fault_addr[VA_W-1:0] >= addr_q[VA_W-1:0]) &&
                      (fault_addr[VA_W-1:0] <= addr_q[VA_W-1:0] + VA_W'(total_q))); // R6
endmodule

// File: tb/mtc_tag_checker_tb_top.sv
module mtc_tag_checker_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [63:0] req_addr;
  logic [8:0]  req_total;
  logic [3:0]  req_esz_log2;
  logic [1:0]  tbi_en;
  logic [1:0]  pg_tagged;
  logic        tag_rd_en;
  logic [50:0] tag_rd_addr;
  logic [7:0]  tag_rd_data;
  logic        busy, done, pass;
  logic [63:0] fault_addr;

  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int done_cnt = 0;
  bit order_err = 1'b0;
  logic [50:0] rd_prev;
  logic [7:0]  tmem [0:255];

  always #2.5ns clk = ~clk;

  mtc_tag_checker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_total(req_total), .req_esz_log2(req_esz_log2), .tbi_en(tbi_en),
    .pg_tagged(pg_tagged), .tag_rd_en(tag_rd_en), .tag_rd_addr(tag_rd_addr),
    .tag_rd_data(tag_rd_data), .busy(busy), .done(done), .pass(pass),
    .fault_addr(fault_addr)
  );

  always @(posedge clk) if (tag_rd_en) tag_rd_data <= tmem[tag_rd_addr[7:0]];

  always @(negedge clk) begin
    if (tag_rd_en) begin
      if (rd_cnt > 0 && tag_rd_addr != rd_prev + 51'd1) order_err = 1'b1;
      rd_prev = tag_rd_addr;
      rd_cnt  = rd_cnt + 1;
    end
    if (done) done_cnt = done_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_addr(input logic [3:0] ptag, input bit b55,
                                          input logic [12:0] lo);
    return {4'h0, ptag, b55, 42'd0, lo};
  endfunction

  task automatic fill(input logic [63:0] a, input int total);
    logic [55:0] lo = a[55:0];
    for (longint g = lo >> 4; g <= (lo + total - 1) >> 4; g++) begin
      if (g[0]) tmem[(g >> 1) & 255][7:4] = a[59:56];
      else      tmem[(g >> 1) & 255][3:0] = a[59:56];
    end
  endtask

  task automatic corrupt(input logic [63:0] a, input int k);
    longint g = (a[55:0] >> 4) + k;
    logic [3:0] x = 4'(1 + $urandom % 15);
    if (g[0]) tmem[(g >> 1) & 255][7:4] ^= x;
    else      tmem[(g >> 1) & 255][3:0] ^= x;
  endtask

  task automatic ref_model(input logic [63:0] a, input int total, input int esz,
                           input logic [1:0] tbi, input logic [1:0] pg,
                           output bit e_pass, output logic [63:0] e_fault,
                           output int e_reads);
    logic [55:0] lo = a[55:0];
    longint g0, g1, cnt, n, lastg, off, msk;
    e_pass = 1'b1; e_fault = '0; e_reads = 0;
    if (!tbi[a[55]]) return;
    g0 = lo >> 4; g1 = (lo + total - 1) >> 4; cnt = g1 - g0 + 1; n = cnt;
    for (longint k = 0; k < cnt; k++) begin
      longint ga = (g0 + k) << 4;
      bit skp = ((ga >> 12) != (lo >> 12)) ? !pg[1] : !pg[0];
      logic [3:0] nib = (((g0 + k) & 1) != 0) ? tmem[((g0 + k) >> 1) & 255][7:4]
                                               : tmem[((g0 + k) >> 1) & 255][3:0];
      if (!skp && nib != a[59:56]) begin n = k; break; end
    end
    lastg = (n < cnt) ? g0 + n : g1;
    e_reads = int'((lastg >> 1) - (g0 >> 1) + 1);
    if (n < cnt) begin
      e_pass = 1'b0;
      off = (n == 0) ? 0 : n * 16 - longint'(lo[3:0]);
      msk = (longint'(1) << esz) - 1;
      off = (off + msk) & ~msk;
      e_fault = a + 64'(off);
    end
  endtask

  task automatic run(input logic [63:0] a, input int total, input int esz,
                     input logic [1:0] tbi, input logic [1:0] pg, input string req);
    bit e_pass; logic [63:0] e_fault; int e_reads; int wd = 0;
    ref_model(a, total, esz, tbi, pg, e_pass, e_fault, e_reads);
    rd_cnt = 0; order_err = 1'b0;
    req_valid = 1'b1; req_addr = a; req_total = 9'(total);
    req_esz_log2 = 4'(esz); tbi_en = tbi; pg_tagged = pg;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && wd < 500) begin @(negedge clk); wd++; end
    chk(wd < 500, req, "completion", wd, 0);
    chk(pass == e_pass, req, "pass", pass, e_pass);
    chk(fault_addr == e_fault, req, "fault_addr", fault_addr, e_fault);
    chk(rd_cnt == e_reads && !order_err, "R8", "tag reads", rd_cnt, e_reads);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] a;
    void'($urandom(32'd2024));
    for (int i = 0; i < 256; i++) tmem[i] = 8'h00;
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_total = '0;
    req_esz_log2 = '0; tbi_en = 2'b11; pg_tagged = 2'b11;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !busy && !tag_rd_en, "R1", "reset outputs",
        {done, busy, tag_rd_en}, 0);

    // R3 R4: aligned single granule, lower nibble
    a = mk_addr(4'hA, 1'b0, 13'h100); fill(a, 16);
    run(a, 16, 4, 2'b11, 2'b11, "R3");
    // R4: odd start, upper nibble then next byte
    a = mk_addr(4'h5, 1'b0, 13'h130); fill(a, 32);
    run(a, 32, 3, 2'b11, 2'b11, "R4");
    // R5 R6: failure in fourth granule, 8-byte elements
    a = mk_addr(4'h3, 1'b0, 13'h208); fill(a, 64); corrupt(a, 3);
    run(a, 64, 3, 2'b11, 2'b11, "R6");
    // R6: same with 32-byte elements, offset rounds up
    run(a, 64, 5, 2'b11, 2'b11, "R6");
    // R5: mismatch at first granule, odd start
    a = mk_addr(4'h9, 1'b1, 13'h470); fill(a, 48); corrupt(a, 0);
    run(a, 48, 0, 2'b11, 2'b11, "R5");
    // R7: page crossing, mismatch on untagged second page
    a = mk_addr(4'h7, 1'b0, 13'hFF0); fill(a, 64); corrupt(a, 2);
    run(a, 64, 2, 2'b11, 2'b01, "R7");
    run(a, 64, 2, 2'b11, 2'b11, "R7");
    // R2: half with checking disabled
    a = mk_addr(4'h1, 1'b1, 13'h600); fill(a, 32); corrupt(a, 0);
    run(a, 32, 4, 2'b01, 2'b11, "R2");

    // R9: request while busy is ignored
    a = mk_addr(4'hC, 1'b0, 13'h800); fill(a, 128); corrupt(a, 6);
    done_cnt = 0;
    begin
      bit e_pass; logic [63:0] e_fault; int e_reads; int wd = 0;
      ref_model(a, 128, 4, 2'b11, 2'b11, e_pass, e_fault, e_reads);
      req_valid = 1'b1; req_addr = a; req_total = 9'd128; req_esz_log2 = 4'd4;
      tbi_en = 2'b11; pg_tagged = 2'b11;
      @(negedge clk);
      req_addr = mk_addr(4'h0, 1'b1, 13'h40); tbi_en = 2'b01;
      @(negedge clk);
      req_valid = 1'b0; tbi_en = 2'b11;
      while (!done && wd < 500) begin @(negedge clk); wd++; end
      chk(pass == e_pass && fault_addr == e_fault, "R9", "busy request ignored",
          fault_addr, e_fault);
      repeat (6) @(negedge clk);
      chk(done_cnt == 1, "R9", "single done pulse", done_cnt, 1);
    end

    // Random mix: R3 R5 R6 R7 R8
    for (int t = 0; t < 60; t++) begin
      int esz = int'($urandom % 5);
      int nel = 1 + int'($urandom % (256 >> esz));
      int total = nel << esz;
      logic [12:0] lo = 13'($urandom % 7936);
      logic [1:0] tbi = ($urandom % 6 == 0) ? 2'($urandom) : 2'b11;
      logic [1:0] pg  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b11;
      a = mk_addr(4'($urandom), 1'($urandom), lo);
      fill(a, total);
      if ($urandom % 2 == 1)
        corrupt(a, int'($urandom % ((((a[55:0] + total - 1) >> 4) - (a[55:0] >> 4)) + 1)));
      run(a, total, esz, tbi, pg, "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule